// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block keeps the configuration registers with which the power-management function of a peripheral bridge places two windows in host I/O space. One is a 128-byte window for the power-management registers and the other a 16-byte window for the SMBus controller. Software writes and reads these registers one byte at a time through a simple configuration port. The block holds the address bits that software may not change at fixed values, and it compares every incoming 16-bit I/O address against both windows. It raises one hit signal per window.

The block also produces the level-sensitive SCI interrupt. It combines a PM1 status word and a PM1 enable word, which come from the register file inside the window. The interrupt reaches the output only when the function reports a nonzero interrupt pin. The registers inside the windows, the PM timer and the SMBus engine sit outside this block.

Top module: `pm_io_window_decoder`

## Requirements
- R1: After reset, every register reads zero except the low byte of each base register. The PM base register (offsets 0x48..0x4B, little-endian) and the SMBus base register (0x90..0x93) each read 0x00000001. Both windows are disabled, so neither hit output is high. The interrupt-pin byte at 0x3D reads the parameter INT_PIN_RST (default 0x01).
- R2: After any byte write to the PM base register, the stored 32-bit value equals (merged & 0x0000FF80) | 1. Here merged is the old value with the written byte replaced. As a result, byte 0x48 reads (data & 0x80) | 0x01, and bytes 0x4A and 0x4B read 0.
- R3: After any byte write to the SMBus base register, the stored value equals (merged & 0x0000FFF0) | 1. As a result, byte 0x90 reads (data & 0xF0) | 0x01, and bytes 0x92 and 0x93 read 0.
- R4: A write to one byte of a base register keeps the other bytes of that register, apart from the forced bits.
- R5: A write to the SMBus control byte at 0xD2 keeps only bits 3:0, so bits 7:4 always read 0.
- R6: pm_hit_o is high exactly when bit 7 of the PM control byte at 0x41 is set and io_addr_i[15:7] equals PM base bits 15:7.
- R7: smb_hit_o is high exactly when bit 0 of byte 0xD2 is set and io_addr_i[15:4] equals SMBus base bits 15:4.
- R8: sci_o is high when the interrupt-pin byte is nonzero and any of four PM1 sources has both its status bit and its enable bit set. The sources are bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (RTC). Other bits never raise sci_o.
- R9: While the interrupt-pin byte at 0x3D is zero, sci_o stays low whatever the PM1 status and enable words hold. That byte is writable.
- R10: Offsets other than 0x3D, 0x41, 0x48..0x4B, 0x90..0x93 and 0xD2 read as zero, and writes to them change no register and no hit output.
- R11: A configuration write takes effect at the rising clock edge while cfg_we_i is high. cfg_rdata_o is combinational from cfg_addr_i and shows the old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration byte write enable |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| io_addr_i | input | 16 | Host I/O address to decode |
| pm_hit_o | output | 1 | Address falls in the enabled PM window |
| smb_hit_o | output | 1 | Address falls in the enabled SMBus window |
| pm1_sts_i | input | 16 | PM1 event status word |
| pm1_en_i | input | 16 | PM1 event enable word |
| sci_o | output | 1 | Level SCI interrupt |

## Verification
Base registers receive random byte writes at every lane, mixed with directed writes of all-ones. All-ones data shows whether the forced low bits and the cleared upper half really override the written data. Lane-by-lane writes show whether the merged value is preserved. I/O addresses are drawn in three ways: at the base with random low bits, just outside either edge of the window, and fully random. This separates a correct comparison width from one that is a bit too wide or too narrow, and it also exposes a missing enable gate. SCI is driven with each source bit alone, with non-source bits only, and with random words, with the interrupt pin both zero and nonzero. This separates the source mask from the pin gating.

// File: rtl/pm_dec_pkg.sv
package pm_dec_pkg;
  localparam int unsigned CFG_AW = 8;
  localparam logic [CFG_AW-1:0] OFF_INT_PIN  = 8'h3D;
  localparam logic [CFG_AW-1:0] OFF_PM_CTL   = 8'h41;
  localparam logic [CFG_AW-1:0] OFF_PM_BASE  = 8'h48;
  localparam logic [CFG_AW-1:0] OFF_SMB_BASE = 8'h90;
  localparam logic [CFG_AW-1:0] OFF_SMB_CTL  = 8'hD2;
  localparam int unsigned PM_EN_BIT  = 7;
  localparam int unsigned SMB_EN_BIT = 0;
  // timer(0), global lock(5), power button(8), rtc(10)
  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
endpackage

// File: rtl/pm_base_reg.sv
module pm_base_reg #(
  parameter int unsigned IO_W      = 16,
  parameter int unsigned SPAN_LOG2 = 7,
  parameter logic [7:0]  OFFSET    = 8'h48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [31:0] value_o,
  output logic [7:0]  rdata_o
);
  localparam logic [31:0] IO_MASK = (32'd1 << IO_W) - 32'd1;
  localparam logic [31:0] LOW_MASK = (32'd1 << SPAN_LOG2) - 32'd1;
  localparam logic [31:0] KEEP = IO_MASK & ~LOW_MASK;

  logic [31:0] q;
  logic [31:0] merged;
  logic        sel;
  logic [1:0]  lane;

  assign sel  = (addr_i[7:2] == OFFSET[7:2]);
  assign lane = addr_i[1:0];

  always_comb begin
    merged = q;
    merged[{lane, 3'b000} +: 8] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q <= 32'd1;
    else if (we_i && sel) q <= (merged & KEEP) | 32'd1;
  end

  assign value_o = q;
  assign rdata_o = sel ? q[{lane, 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/pm_byte_reg.sv
module pm_byte_reg #(
  parameter logic [7:0] OFFSET = 8'h41,
  parameter logic [7:0] WMASK  = 8'hFF,
  parameter logic [7:0] RST    = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] value_o,
  output logic [7:0] rdata_o
);
  logic [7:0] q;
  logic       sel;

  assign sel = (addr_i == OFFSET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q <= RST;
    else if (we_i && sel) q <= wdata_i & WMASK;
  end

  assign value_o = q;
  assign rdata_o = sel ? q : 8'h00;
endmodule

// File: rtl/pm_io_window.sv
module pm_io_window #(
  parameter int unsigned IO_W      = 16,
  parameter int unsigned SPAN_LOG2 = 7
) (
  input  logic            en_i,
  input  logic [IO_W-1:0] base_i,
  input  logic [IO_W-1:0] addr_i,
  output logic            hit_o
);
  assign hit_o = en_i && (addr_i[IO_W-1:SPAN_LOG2] == base_i[IO_W-1:SPAN_LOG2]);
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
  import pm_dec_pkg::*;
(
  input  logic [15:0] sts_i,
  input  logic [15:0] en_i,
  input  logic [7:0]  int_pin_i,
  output logic        sci_o
);
  logic pending;
  assign pending = |(sts_i & en_i & SCI_SRC_MASK);
  assign sci_o   = pending && (int_pin_i != 8'h00);
endmodule

// File: rtl/pm_io_window_decoder.sv
module pm_io_window_decoder
  import pm_dec_pkg::*;
#(
  parameter int unsigned IO_W          = 16,
  parameter int unsigned PM_SPAN_LOG2  = 7,
  parameter int unsigned SMB_SPAN_LOG2 = 4,
  parameter logic [7:0]  INT_PIN_RST   = 8'h01
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_addr_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_rdata_o,
  input  logic [IO_W-1:0] io_addr_i,
  output logic            pm_hit_o,
  output logic            smb_hit_o,
  input  logic [15:0]     pm1_sts_i,
  input  logic [15:0]     pm1_en_i,
  output logic            sci_o
);
  localparam int unsigned NWIN = 2;

  logic [31:0] pm_base_q, smb_base_q;
  logic [7:0]  pm_ctl_q, smb_ctl_q, int_pin_q;
  logic [7:0]  rd_pm_base, rd_smb_base, rd_pm_ctl, rd_smb_ctl, rd_pin;

  pm_base_reg #(.IO_W(IO_W), .SPAN_LOG2(PM_SPAN_LOG2), .OFFSET(OFF_PM_BASE)) u_pm_base (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .value_o(pm_base_q), .rdata_o(rd_pm_base));

  pm_base_reg #(.IO_W(IO_W), .SPAN_LOG2(SMB_SPAN_LOG2), .OFFSET(OFF_SMB_BASE)) u_smb_base (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .value_o(smb_base_q), .rdata_o(rd_smb_base));

  pm_byte_reg #(.OFFSET(OFF_PM_CTL), .WMASK(8'hFF), .RST(8'h00)) u_pm_ctl (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .value_o(pm_ctl_q), .rdata_o(rd_pm_ctl));

  pm_byte_reg #(.OFFSET(OFF_SMB_CTL), .WMASK(8'h0F), .RST(8'h00)) u_smb_ctl (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .value_o(smb_ctl_q), .rdata_o(rd_smb_ctl));

  pm_byte_reg #(.OFFSET(OFF_INT_PIN), .WMASK(8'hFF), .RST(INT_PIN_RST)) u_int_pin (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .value_o(int_pin_q), .rdata_o(rd_pin));

  // selects are disjoint, so the read mux is a plain OR
  assign cfg_rdata_o = rd_pm_base | rd_smb_base | rd_pm_ctl | rd_smb_ctl | rd_pin;

  logic [NWIN-1:0]            win_en;
  logic [NWIN-1:0][IO_W-1:0]  win_base;
  logic [NWIN-1:0]            win_hit;

  assign win_en[0]   = pm_ctl_q[PM_EN_BIT];
  assign win_en[1]   = smb_ctl_q[SMB_EN_BIT];
  assign win_base[0] = pm_base_q[IO_W-1:0];
  assign win_base[1] = smb_base_q[IO_W-1:0];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int unsigned SPAN = (w == 0) ? PM_SPAN_LOG2 : SMB_SPAN_LOG2;
    pm_io_window #(.IO_W(IO_W), .SPAN_LOG2(SPAN)) u_win (
      .en_i(win_en[w]), .base_i(win_base[w]), .addr_i(io_addr_i), .hit_o(win_hit[w]));
  end

  assign pm_hit_o  = win_hit[0];
  assign smb_hit_o = win_hit[1];

  pm_sci_gen u_sci (
    .sts_i(pm1_sts_i), .en_i(pm1_en_i), .int_pin_i(int_pin_q), .sci_o(sci_o));
endmodule

// File: rtl/pm_io_window_decoder_chk.sv
module pm_io_window_decoder_chk
  import pm_dec_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [7:0]  cfg_addr_i,
  input logic        pm_hit_o,
  input logic        smb_hit_o,
  input logic [15:0] pm1_sts_i,
  input logic [15:0] pm1_en_i,
  input logic        sci_o,
  input logic [31:0] pm_base_q,
  input logic [31:0] smb_base_q,
  input logic [7:0]  pm_ctl_q,
  input logic [7:0]  smb_ctl_q,
  input logic [7:0]  int_pin_q
);
  logic other_wr;
  assign other_wr = cfg_we_i && (cfg_addr_i[7:2] != OFF_PM_BASE[7:2]) &&
                    (cfg_addr_i[7:2] != OFF_SMB_BASE[7:2]) && (cfg_addr_i != OFF_PM_CTL) &&
                    (cfg_addr_i != OFF_SMB_CTL) && (cfg_addr_i != OFF_INT_PIN);

  assert_pm_base_forced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_base_q[6:0] == 7'h01) && (pm_base_q[31:16] == 16'h0000));
  assert_smb_base_forced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smb_base_q[3:0] == 4'h1) && (smb_base_q[31:16] == 16'h0000));
  assert_smb_ctl_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_ctl_q[7:4] == 4'h0);
  assert_pm_hit_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> pm_ctl_q[PM_EN_BIT]);
  assert_smb_hit_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> smb_ctl_q[SMB_EN_BIT]);
  assert_sci_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pm1_sts_i & pm1_en_i & SCI_SRC_MASK) == 16'h0) |-> !sci_o);
  assert_sci_pin_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pin_q == 8'h00) |-> !sci_o);
  assert_other_write_inert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_wr |=> ($stable(pm_base_q) && $stable(smb_base_q) && $stable(pm_ctl_q) &&
                  $stable(smb_ctl_q) && $stable(int_pin_q)));
endmodule

bind pm_io_window_decoder pm_io_window_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .pm_hit_o(pm_hit_o), .smb_hit_o(smb_hit_o), .pm1_sts_i(pm1_sts_i), .pm1_en_i(pm1_en_i),
  .sci_o(sci_o), .pm_base_q(pm_base_q), .smb_base_q(smb_base_q), .pm_ctl_q(pm_ctl_q),
  .smb_ctl_q(smb_ctl_q), .int_pin_q(int_pin_q));

// File: tb/pm_io_window_decoder_tb.sv
module pm_io_window_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = 16'h0000;
  logic        pm_hit, smb_hit, sci;
  logic [15:0] sts = 16'h0, en = 16'h0;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [31:0] m_pm_base, m_smb_base;
  logic [7:0]  m_pm_ctl, m_smb_ctl, m_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_io_window_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .io_addr_i(io_addr),
    .pm_hit_o(pm_hit), .smb_hit_o(smb_hit), .pm1_sts_i(sts), .pm1_en_i(en), .sci_o(sci));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] lane,
                                        input logic [7:0] d);
    logic [31:0] r = old;
    r[lane*8 +: 8] = d;
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a[7:2] == 6'h12) return m_pm_base[a[1:0]*8 +: 8];
    if (a[7:2] == 6'h24) return m_smb_base[a[1:0]*8 +: 8];
    if (a == 8'h41) return m_pm_ctl;
    if (a == 8'hD2) return m_smb_ctl;
    if (a == 8'h3D) return m_pin;
    return 8'h00;
  endfunction

  function automatic logic exp_pm_hit(input logic [15:0] a);
    return m_pm_ctl[7] && (a[15:7] == m_pm_base[15:7]);
  endfunction

  function automatic logic exp_smb_hit(input logic [15:0] a);
    return m_smb_ctl[0] && (a[15:4] == m_smb_base[15:4]);
  endfunction

  function automatic logic exp_sci(input logic [15:0] s, input logic [15:0] e);
    return (m_pin != 8'h00) && (|(s & e & 16'h0521));
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a[7:2] == 6'h12) m_pm_base = (merge(m_pm_base, a[1:0], d) & 32'h0000FF80) | 32'd1;
    else if (a[7:2] == 6'h24) m_smb_base = (merge(m_smb_base, a[1:0], d) & 32'h0000FFF0) | 32'd1;
    else if (a == 8'h41) m_pm_ctl = d;
    else if (a == 8'hD2) m_smb_ctl = d & 8'h0F;
    else if (a == 8'h3D) m_pin = d;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_read(input string req, input logic [7:0] a);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, {24'h0, cfg_rdata}, {24'h0, exp_rd(a)});
  endtask

  task automatic check_hits(input string req, input logic [15:0] a);
    @(negedge clk);
    io_addr = a;
    #1;
    check({req, " pm_hit R6"}, {31'h0, pm_hit}, {31'h0, exp_pm_hit(a)});
    check({req, " smb_hit R7"}, {31'h0, smb_hit}, {31'h0, exp_smb_hit(a)});
  endtask

  task automatic check_sci(input string req, input logic [15:0] s, input logic [15:0] e);
    @(negedge clk);
    sts = s; en = e;
    #1 check(req, {31'h0, sci}, {31'h0, exp_sci(s, e)});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addr_pool [12];
    addr_pool = '{8'h3D, 8'h41, 8'h48, 8'h49, 8'h4A, 8'h4B,
                  8'h90, 8'h91, 8'h92, 8'h93, 8'hD2, 8'h40};
    void'($urandom(32'd20240415));
    m_pm_base = 32'd1; m_smb_base = 32'd1; m_pm_ctl = 8'h00; m_smb_ctl = 8'h00; m_pin = 8'h01;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    foreach (addr_pool[i]) check_read("R1 reset read", addr_pool[i]);
    check_hits("R1 reset", 16'h0000);
    check_hits("R1 reset", 16'h0005);

    // R2 / R4 PM base forcing and lane preservation
    cfg_write(8'h48, 8'hFF);
    check_read("R2 pm base byte0", 8'h48);
    check(" R2 pm base byte0 value", {24'h0, exp_rd(8'h48)}, 32'h81);
    cfg_write(8'h49, 8'h12);
    check_read("R4 pm base byte0 kept", 8'h48);
    check_read("R4 pm base byte1", 8'h49);
    cfg_write(8'h4A, 8'hAB);
    cfg_write(8'h4B, 8'hCD);
    check_read("R2 pm base byte2 zero", 8'h4A);
    check_read("R2 pm base byte3 zero", 8'h4B);
    check_read("R4 pm base byte1 kept", 8'h49);

    // R3 SMBus base
    cfg_write(8'h90, 8'hFF);
    check_read("R3 smb base byte0", 8'h90);
    cfg_write(8'h91, 8'h5A);
    cfg_write(8'h93, 8'hFF);
    check_read("R3 smb base byte3 zero", 8'h93);
    check_read("R4 smb base byte0 kept", 8'h90);

    // R5 control byte masking
    cfg_write(8'hD2, 8'hFF);
    check_read("R5 smb ctl", 8'hD2);

    // R11 write lands at the edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h41; cfg_wdata = 8'h80;
    #1 check("R11 old value before edge", {24'h0, cfg_rdata}, 32'h00);
    @(negedge clk);
    cfg_we = 1'b0; model_write(8'h41, 8'h80);
    #1 check("R11 new value after edge", {24'h0, cfg_rdata}, 32'h80);

    // R6 / R7 window edges
    check_hits("window base", 16'h1280);
    check_hits("window top", 16'h12FF);
    check_hits("below pm", 16'h127F);
    check_hits("above pm", 16'h1300);
    check_hits("smb base", 16'h5AF0);
    check_hits("smb top", 16'h5AFF);
    check_hits("below smb", 16'h5AEF);
    check_hits("above smb", 16'h5B00);
    cfg_write(8'h41, 8'h7F);
    check_hits("pm disabled", 16'h1280);
    cfg_write(8'hD2, 8'h0E);
    check_hits("smb disabled", 16'h5AF3);

    // R10 other offsets
    cfg_write(8'h40, 8'hFF);
    cfg_write(8'h94, 8'hFF);
    cfg_write(8'h3C, 8'hFF);
    check_read("R10 other read", 8'h40);
    check_read("R10 other read", 8'h94);
    check_read("R10 pm ctl unchanged", 8'h41);
    check_read("R10 smb base unchanged", 8'h90);
    check_read("R10 pin unchanged", 8'h3D);

    // R8 each source alone, non-source bits
    for (int b = 0; b < 16; b++) check_sci("R8 single bit", 16'h1 << b, 16'hFFFF);
    check_sci("R8 status without enable", 16'h0521, 16'hFADE);
    // R9 pin gating
    cfg_write(8'h3D, 8'h00);
    check_sci("R9 pin zero", 16'hFFFF, 16'hFFFF);
    check_sci("R9 pin zero timer", 16'h0001, 16'h0001);
    cfg_write(8'h3D, 8'h02);
    check_sci("R9 pin nonzero", 16'h0400, 16'h0400);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : addr_pool[$urandom % 12];
      d = 8'($urandom);
      cfg_write(a, d);
      check_read("R2 R3 R5 R10 random read", addr_pool[$urandom % 12]);
      case ($urandom % 3)
        0: check_hits("random near pm", {m_pm_base[15:7], 7'($urandom)});
        1: check_hits("random near smb", {m_smb_base[15:4], 4'($urandom)});
        default: check_hits("random addr", 16'($urandom));
      endcase
      check_sci("R8 R9 random sci", 16'($urandom), 16'($urandom));
    end

    finish_run();
  end
endmodule